// File: doc/BRIEF.md
# Sense-Configurable External Interrupt Controller

This block watches a set of external interrupt pins and turns them into one interrupt request per channel toward a CPU. Every pin is brought into the block clock through a two-stage synchroniser. Each channel then applies its own sense rule, which is either an active level (low or high) or a synchronous edge (falling, rising or either). The result is a per-channel detect flag. A channel raises its interrupt output only when software has also enabled it.

Software reaches the block through a plain 32-bit register port made of an address, a write strobe, write data and a combinational read-data bus. Enables have no read-modify-write register. Instead, one address sets enable bits and another clears them, so independent handlers can unmask and mask channels without racing each other. A handler reads the detect register, acknowledges edge events by writing ones back to it, and picks a channel's sense rule through that channel's configuration word.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A write to offset 0x008 sets every enable bit whose write-data bit is one. Enable bits whose write-data bit is zero keep their value. Reading 0x008 returns zero.
- R2: A write to offset 0x004 clears every enable bit whose write-data bit is one. Bits written as zero keep their value. Reading 0x004 returns the enable bits in bits [N_CH-1:0].
- R3: Offset 0x100 reads the raw detect bits, with channel n in bit n. Writing a one to bit n clears an edge-mode detect bit one clock later. Writing a zero has no effect.
- R4: Channel n has a configuration word at 0x180 + 4*n. Only write-data bits [5:0] are stored, and a read returns them zero-extended. Configuration addresses for channels at or above N_CH, and all other unmapped addresses, read zero and ignore writes.
- R5: Sense code 0x01 (level-low) and sense code 0x02 (level-high) make the detect bit equal the active level of the synchronised pin. A clear write cannot remove the bit while that level persists.
- R6: Sense codes 0x04 (falling), 0x08 (rising) and 0x0C (both) set the detect bit on the matching synchronised transition. The bit stays set until a clear write, and a transition detected in the same cycle as a clear write wins.
- R7: For any other sense code, including 0x00 and 0x3F, the channel's detect bit is held at zero.
- R8: irq_o[n] is one exactly when detect bit n and enable bit n are both one.
- R9: Offset 0x000 reads the detect bits ANDed with the enable bits. Writes to 0x000 change nothing.
- R10: After reset, all enable bits, detect bits and configuration words are zero.
- R11: A pin change held from just after clock edge k-1 reaches the detect bit at clock edge k+2. That is two synchroniser stages plus the detect register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write strobe, acted on at the clock edge |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| pins_i | input | N_CH | Asynchronous external interrupt pins |
| irq_o | output | N_CH | Per-channel interrupt requests |

## Verification
The bench builds the block with N_CH = 6, ADDR_W = 12 and DATA_W = 32. Six channels are enough to give one channel to each of the five valid sense codes and a sixth to an unlisted code, all running side by side. With fewer channels than configuration slots, the bench can write and read configuration addresses for absent channels (0x198 to 0x1FC) and confirm they stay zero. The high unused bits of the status and enable words are then also visible as zeros. The behavioural model follows the pin history through a queue, so it predicts the three-edge latency and edge/clear collisions on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int unsigned MAX_CH = 32;
  localparam int unsigned IDX_W  = 5;

  localparam logic [5:0] SNS_LOW  = 6'h01;
  localparam logic [5:0] SNS_HIGH = 6'h02;
  localparam logic [5:0] SNS_FALL = 6'h04;
  localparam logic [5:0] SNS_RISE = 6'h08;
  localparam logic [5:0] SNS_BOTH = 6'h0C;

  localparam logic [11:0] OFS_PEND   = 12'h000;
  localparam logic [11:0] OFS_EN_CLR = 12'h004;
  localparam logic [11:0] OFS_EN_SET = 12'h008;
  localparam logic [11:0] OFS_DET    = 12'h100;
  localparam logic [11:0] OFS_CFG    = 12'h180;

  typedef enum logic [2:0] {
    M_OFF, M_LOW, M_HIGH, M_FALL, M_RISE, M_BOTH
  } sense_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_PEND, RD_EN, RD_DET, RD_CFG
  } rd_sel_e;

  function automatic sense_e sense_decode(input logic [5:0] code);
    case (code)
      SNS_LOW:  return M_LOW;
      SNS_HIGH: return M_HIGH;
      SNS_FALL: return M_FALL;
      SNS_RISE: return M_RISE;
      SNS_BOTH: return M_BOTH;
      default:  return M_OFF;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   smp_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   det_o
);
  logic prev_q, det_q, det_d;
  logic rise, fall;

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    case (mode_i)
      M_LOW:   det_d = ~smp_i;
      M_HIGH:  det_d = smp_i;
      M_FALL:  det_d = fall | (det_q & ~clr_i);
      M_RISE:  det_d = rise | (det_q & ~clr_i);
      M_BOTH:  det_d = rise | fall | (det_q & ~clr_i);
      default: det_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= smp_i;
      det_q  <= det_d;
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/ext_irq_decode.sv
module ext_irq_decode
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rd_sel_e           sel_o,
  output logic              set_o,
  output logic [N_CH-1:0]   cfg_hit_o
);
  localparam int unsigned HI_W = ADDR_W - 7;

  logic [IDX_W-1:0] idx;
  logic             in_cfg;

  assign idx    = addr_i[6:2];
  assign in_cfg = (addr_i[ADDR_W-1:7] == HI_W'(OFS_CFG >> 7)) && (addr_i[1:0] == 2'b00)
                  && (32'(idx) < N_CH);
  assign set_o  = (addr_i == ADDR_W'(OFS_EN_SET));

  always_comb begin
    if (addr_i == ADDR_W'(OFS_PEND))        sel_o = RD_PEND;
    else if (addr_i == ADDR_W'(OFS_EN_CLR)) sel_o = RD_EN;
    else if (addr_i == ADDR_W'(OFS_DET))    sel_o = RD_DET;
    else if (in_cfg)                        sel_o = RD_CFG;
    else                                    sel_o = RD_NONE;
  end

  always_comb begin
    for (int i = 0; i < N_CH; i++) cfg_hit_o[i] = in_cfg && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   pins_i,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0]      smp;
  logic [N_CH-1:0]      en_q, det_q, clr;
  logic [N_CH-1:0][5:0] cfg_q;
  logic [N_CH-1:0]      cfg_hit;
  rd_sel_e              sel;
  logic                 set_hit;
  logic [5:0]           cfg_rd;

  irq_sync #(.W(N_CH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (smp)
  );

  ext_irq_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) i_decode (
    .addr_i   (addr_i),
    .sel_o    (sel),
    .set_o    (set_hit),
    .cfg_hit_o(cfg_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i && sel == RD_EN) begin
      en_q <= en_q & ~wdata_i[N_CH-1:0];
    end else if (we_i && set_hit) begin
      en_q <= en_q | wdata_i[N_CH-1:0];
    end
  end

  assign clr = (we_i && sel == RD_DET) ? wdata_i[N_CH-1:0] : '0;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cfg_q[g] <= '0;
      else if (we_i && cfg_hit[g])  cfg_q[g] <= wdata_i[5:0];
    end

    irq_detect i_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (smp[g]),
      .mode_i(sense_decode(cfg_q[g])),
      .clr_i (clr[g]),
      .det_o (det_q[g])
    );
  end

  assign irq_o = det_q & en_q;

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < N_CH; i++) if (cfg_hit[i]) cfg_rd = cfg_q[i];
  end

  always_comb begin
    case (sel)
      RD_PEND: rdata_o = DATA_W'(det_q & en_q);
      RD_EN:   rdata_o = DATA_W'(en_q);
      RD_DET:  rdata_o = DATA_W'(det_q);
      RD_CFG:  rdata_o = DATA_W'(cfg_rd);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 we_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [N_CH-1:0]      en_q,
  input logic [N_CH-1:0]      det_q,
  input logic [N_CH-1:0][5:0] cfg_q
);
  logic [N_CH-1:0] edge_m, bad_m, clr_m, keep_m;
  logic            wr_set, wr_clr;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      edge_m[i] = sense_decode(cfg_q[i]) inside {M_FALL, M_RISE, M_BOTH};
      bad_m[i]  = sense_decode(cfg_q[i]) == M_OFF;
    end
  end

  assign clr_m  = (we_i && addr_i == ADDR_W'(OFS_DET)) ? wdata_i[N_CH-1:0] : '0;
  assign keep_m = det_q & edge_m & ~clr_m;
  assign wr_set = we_i && addr_i == ADDR_W'(OFS_EN_SET);
  assign wr_clr = we_i && addr_i == ADDR_W'(OFS_EN_CLR);

  // R1
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_q & $past(wdata_i[N_CH-1:0])) == $past(wdata_i[N_CH-1:0])));

  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_q & $past(wdata_i[N_CH-1:0])) == '0));

  // R6
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(keep_m) & edge_m & ~det_q) == '0));

  // R7
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((det_q & $past(bad_m)) == '0));

  // R9
  pend_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_PEND)) |-> ((rdata_o & ~DATA_W'(en_q)) == '0));

  // R10
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (en_q == '0 && det_q == '0 && cfg_q == '0));
endmodule

bind ext_irq_ctrl ext_irq_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .en_q   (en_q),
  .det_q  (det_q),
  .cfg_q  (cfg_q)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  localparam int NCH = 6;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic           we = 1'b0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] pins = '0;
  logic [NCH-1:0] irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.N_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) i_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pins_i(pins), .irq_o(irq)
  );

  // reference model
  logic [NCH-1:0] m_en, m_det;
  logic [5:0]     m_cfg [NCH];
  logic [NCH-1:0] hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_det = '0;
      for (int i = 0; i < NCH; i++) m_cfg[i] = '0;
      hist = '{'0, '0, '0};
    end else begin : mdl
      logic [NCH-1:0] cur, prv, clr;
      int idx;
      cur = hist[1]; prv = hist[2];
      clr = (we && addr == 12'h100) ? wdata[NCH-1:0] : '0;
      for (int c = 0; c < NCH; c++) begin
        case (m_cfg[c])
          6'h01: m_det[c] = ~cur[c];
          6'h02: m_det[c] = cur[c];
          6'h04: m_det[c] = (prv[c] & ~cur[c]) | (m_det[c] & ~clr[c]);
          6'h08: m_det[c] = (~prv[c] & cur[c]) | (m_det[c] & ~clr[c]);
          6'h0C: m_det[c] = (prv[c] ^ cur[c]) | (m_det[c] & ~clr[c]);
          default: m_det[c] = 1'b0;
        endcase
      end
      if (we) begin
        if (addr == 12'h004) m_en = m_en & ~wdata[NCH-1:0];
        if (addr == 12'h008) m_en = m_en | wdata[NCH-1:0];
        if (addr >= 12'h180 && addr <= 12'h1FC && addr[1:0] == 2'b00) begin
          idx = int'(addr - 12'h180) >> 2;
          if (idx < NCH) m_cfg[idx] = wdata[5:0];
        end
      end
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    int idx;
    if (a == 12'h000) return DW'(m_det & m_en);
    if (a == 12'h004) return DW'(m_en);
    if (a == 12'h100) return DW'(m_det);
    if (a >= 12'h180 && a <= 12'h1FC && a[1:0] == 2'b00) begin
      idx = int'(a - 12'h180) >> 2;
      return (idx < NCH) ? DW'(m_cfg[idx]) : '0;
    end
    return '0;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    if (a == 12'h004) return "R2";
    if (a == 12'h100) return "R3";
    if (a >= 12'h180 && a <= 12'h1FF) return "R4";
    return "R9";
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8", DW'(irq), DW'(m_det & m_en));
      chk(tag_of(addr), rdata, exp_rd(addr));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    addr = a;
    @(negedge clk); chk(req, rdata, exp);
    step();
  endtask

  task automatic rd_bit(input string req, input logic [AW-1:0] a, input int b, input logic exp);
    addr = a;
    @(negedge clk); chk(req, DW'(rdata[b]), DW'(exp));
    step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    logic [5:0] codes [8];
    logic [AW-1:0] rdl [12];
    codes = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h03, 6'h3F};
    rdl = '{12'h000, 12'h004, 12'h008, 12'h100, 12'h180, 12'h184,
            12'h188, 12'h18C, 12'h190, 12'h194, 12'h198, 12'h102};
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 addr = 12'h100;
    @(negedge clk);
    chk("R10", rdata, '0);
    chk("R10", DW'(irq), '0);
    @(posedge clk); #2 rst_n = 1'b1;
    rd_chk("R10", 12'h004, '0);
    rd_chk("R10", 12'h180, '0);

    wr(12'h180, 32'h01);
    wr(12'h184, 32'h02);
    wr(12'h188, 32'h04);
    wr(12'h18C, 32'h08);
    wr(12'h190, 32'h0C);
    wr(12'h194, 32'hFFFF_FFFF);
    rd_chk("R4", 12'h194, 32'h3F);
    rd_chk("R4", 12'h18C, 32'h08);
    rd_chk("R4", 12'h1FC, '0);
    rd_chk("R1", 12'h008, '0);
    wr(12'h008, 32'h3F);
    rd_chk("R1", 12'h004, 32'h3F);
    wr(12'h008, 32'h0);
    rd_chk("R1", 12'h004, 32'h3F);

    // R11 latency on level-high channel 1
    addr = 12'h100; pins[1] = 1'b1;
    @(posedge clk); @(negedge clk); chk("R11", DW'(rdata[1]), 0);
    @(posedge clk); @(negedge clk); chk("R11", DW'(rdata[1]), 0);
    @(posedge clk); @(negedge clk); chk("R11", DW'(rdata[1]), 1);
    chk("R8", DW'(irq[1]), 1);
    @(posedge clk); #2;

    // R5 level modes
    pins[1] = 1'b0; idle(3);
    rd_bit("R5", 12'h100, 1, 1'b0);
    wr(12'h100, 32'h01);
    rd_bit("R5", 12'h100, 0, 1'b1);

    // R6 rising on channel 3
    pins[3] = 1'b1; idle(3);
    rd_bit("R6", 12'h100, 3, 1'b1);
    pins[3] = 1'b0; idle(4);
    rd_bit("R6", 12'h100, 3, 1'b1);
    wr(12'h100, 32'h08);
    rd_bit("R3", 12'h100, 3, 1'b0);
    // falling on channel 2
    pins[2] = 1'b1; idle(4);
    rd_bit("R6", 12'h100, 2, 1'b0);
    pins[2] = 1'b0; idle(3);
    rd_bit("R6", 12'h100, 2, 1'b1);
    // both edges on channel 4
    pins[4] = 1'b1; idle(3);
    rd_bit("R6", 12'h100, 4, 1'b1);
    wr(12'h100, 32'h10);
    rd_bit("R3", 12'h100, 4, 1'b0);
    pins[4] = 1'b0; idle(3);
    rd_bit("R6", 12'h100, 4, 1'b1);
    // edge and clear in the same cycle: edge wins
    pins[3] = 1'b1; idle(2);
    wr(12'h100, 32'h08);
    rd_bit("R6", 12'h100, 3, 1'b1);

    // R7 unlisted code on channel 5
    pins[5] = 1'b1; idle(3);
    pins[5] = 1'b0; idle(3);
    rd_bit("R7", 12'h100, 5, 1'b0);

    // R9 / R2 / R8 masking
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R9", 12'h004, 32'h3F);
    wr(12'h004, 32'h01);
    rd_chk("R2", 12'h004, 32'h3E);
    wr(12'h004, 32'h00);
    rd_chk("R2", 12'h004, 32'h3E);
    rd_bit("R9", 12'h000, 0, 1'b0);
    addr = 12'h100;
    @(negedge clk);
    chk("R3", DW'(rdata[0]), 1);
    chk("R8", DW'(irq[0]), 0);
    step();

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      pins = pins ^ NCH'($urandom & $urandom);
      case ($urandom_range(0, 7))
        0: wr(12'h004, $urandom);
        1: wr(12'h008, $urandom);
        2: wr(12'h100, $urandom);
        3: wr(12'h180 + AW'(4 * $urandom_range(0, 7)), DW'(codes[$urandom_range(0, 7)]) | 32'hC0);
        4: wr(12'h000, $urandom);
        default: begin addr = rdl[$urandom_range(0, 11)]; step(); end
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end
endmodule